// File: doc/BRIEF.md
# ROM Bank Mirroring Mapper

This block turns an 8-bit bank number, where each bank covers 8 KB, into a memory target and a bank index inside that target. It also gives a write-enable flag. The lower half of the bank space, banks 00-7F, is served by ROM. How the ROM repeats across that space depends on how many 8 KB banks the ROM holds. Four banks near the top of the space reach the work RAM. An optional card RAM can take over a window of the ROM region. Every other bank is unmapped.

The configuration inputs are held stable after reset: the ROM size in banks, the work-RAM size and the card-RAM mode. The bank number may change every cycle. Each lookup is computed combinationally and then registered, so a result appears one clock after its bank number. The memories sit outside the block. They use the target code and the index to pick the storage, and they gate writes with the flag.

Top module: `bank_mirror_mapper`

## Requirements
- R1: While `rst_n` is low, and after it rises but before the first lookup is registered, `tgt_o`=0, `idx_o`=0 and `wr_o`=0. Target codes: 0 unmapped, 1 ROM, 2 work RAM, 3 card RAM.
- R2: The outputs show the mapping of the `bank_i` value sampled at the previous rising clock edge. They do not change between edges.
- R3: With `rom_cnt_i`=48, a ROM bank b gets the index (base[b/16] + b mod 16) mod 48. The bases per group of 16 are 0,16,0,16,32,32,32,32.
- R4: With `rom_cnt_i`=64, the group bases are 0,16,32,48,32,48,32,48, and the index is taken mod 64.
- R5: With `rom_cnt_i`=96, the group bases are 0,16,32,48,64,80,64,80, and the index is taken mod 96.
- R6: With any other nonzero `rom_cnt_i`, group g has base 16*g, and the index is taken mod `rom_cnt_i`.
- R7: Banks 80-FF, other than the work-RAM banks, give target 0, index 0 and write enable 0.
- R8: Banks F8-FB give target 2 with write enable 1. The index is 0 when `wram_big_i`=0 (8 KB RAM) and bank-F8 when `wram_big_i`=1 (32 KB RAM).
- R9: With `card_mode_i`=1 (192 KB card), banks 68-7F give target 3, index bank-0x68 and write enable 1. This overrides ROM.
- R10: With `card_mode_i`=2 (32 KB card), banks 40-5F give target 3, index bank mod 4 and write enable 1. This overrides ROM. Modes 0 and 3 add no card RAM.
- R11: A ROM target always comes with write enable 0.
- R12: With `rom_cnt_i`=0, the ROM banks that no card window covers are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_i | input | 8 | Bank number to translate |
| rom_cnt_i | input | 8 | ROM size in 8 KB banks |
| wram_big_i | input | 1 | 1 selects a 32 KB work RAM, 0 an 8 KB one |
| card_mode_i | input | 2 | Card RAM: 0/3 none, 1 192 KB at 68-7F, 2 32 KB at 40-5F |
| tgt_o | output | 2 | Target code |
| idx_o | output | 8 | Bank index inside the target |
| wr_o | output | 1 | Target accepts writes |

## Verification
The hardest cases to reach are where the rules interact: the modulo wrap inside a mirrored group for odd or small ROM sizes, a card window laid over a ROM region that is itself mirrored, and a zero ROM size. The stimulus sweeps all 256 banks under every combination of several ROM sizes (48, 64, 96, 32, 128, 5 and 0), both work-RAM sizes and all four card modes. Each result is compared with a value the bench works out arithmetically.

// File: rtl/bank_mirror_pkg.sv
package bank_mirror_pkg;
    localparam int BANK_W     = 8;
    localparam int GROUPS     = 8;
    localparam int WRAM_BANKS = 4;

    localparam logic [BANK_W-1:0] BIG_CARD_LO   = 8'h68;
    localparam logic [BANK_W-1:0] BIG_CARD_HI   = 8'h7F;
    localparam logic [BANK_W-1:0] SMALL_CARD_LO = 8'h40;
    localparam logic [BANK_W-1:0] SMALL_CARD_HI = 8'h5F;
    localparam logic [BANK_W-1:0] WRAM_LO       = 8'hF8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_WRAM = 2'd2,
        TGT_CARD = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [BANK_W-1:0] idx;
        logic              wr;
    } map_t;

    // Start bank of a 16-bank group, chosen by ROM size
    function automatic logic [BANK_W-1:0] group_base(input logic [BANK_W-1:0] cnt,
                                                     input logic [2:0] g);
        logic [BANK_W-1:0] plain;
        plain = {1'b0, g, 4'b0000};
        case (cnt)
            8'd48:   group_base = g[2] ? 8'h20 : (g[0] ? 8'h10 : 8'h00);
            8'd64:   group_base = (g < 3'd2) ? plain : (g[0] ? 8'h30 : 8'h20);
            8'd96:   group_base = g[2] ? (g[0] ? 8'h50 : 8'h40) : plain;
            default: group_base = plain;
        endcase
    endfunction
endpackage

// File: rtl/rom_mirror.sv
module rom_mirror
    import bank_mirror_pkg::*;
#(
    parameter int BW  = BANK_W,
    parameter int NGR = GROUPS
) (
    input  logic [BW-1:0] bank_i,
    input  logic [BW-1:0] rom_cnt_i,
    output logic          rom_ok_o,
    output logic [BW-1:0] rom_idx_o
);
    localparam int GSEL_W = $clog2(NGR);
    localparam int LOW_W  = BW - 1 - GSEL_W;

    logic [BW-1:0]     base [NGR];
    logic [GSEL_W-1:0] grp;
    logic [BW-1:0]     sum;

    for (genvar g = 0; g < NGR; g++) begin : g_base
        assign base[g] = group_base(rom_cnt_i, 3'(g));
    end

    assign grp = bank_i[BW-2:LOW_W];
    assign sum = base[grp] + BW'(bank_i[LOW_W-1:0]);

    always_comb begin
        rom_ok_o  = !bank_i[BW-1] && (rom_cnt_i != '0);
        rom_idx_o = '0;
        if (rom_cnt_i != '0) begin
            rom_idx_o = sum % rom_cnt_i;
        end
    end
endmodule

// File: rtl/ram_windows.sv
module ram_windows
    import bank_mirror_pkg::*;
#(
    parameter int BW = BANK_W
) (
    input  logic [BW-1:0] bank_i,
    input  logic          wram_big_i,
    input  logic [1:0]    card_mode_i,
    output logic          wram_hit_o,
    output logic [BW-1:0] wram_idx_o,
    output logic          card_hit_o,
    output logic [BW-1:0] card_idx_o
);
    localparam int WR_W = $clog2(WRAM_BANKS);

    logic [BW-1:0] wram_off;
    assign wram_off = bank_i - WRAM_LO;

    always_comb begin
        wram_hit_o = (bank_i >= WRAM_LO) && (bank_i < WRAM_LO + BW'(WRAM_BANKS));
        wram_idx_o = wram_big_i ? BW'(wram_off[WR_W-1:0]) : '0;

        card_hit_o = 1'b0;
        card_idx_o = '0;
        case (card_mode_i)
            2'd1: if (bank_i >= BIG_CARD_LO && bank_i <= BIG_CARD_HI) begin
                card_hit_o = 1'b1;
                card_idx_o = bank_i - BIG_CARD_LO;
            end
            2'd2: if (bank_i >= SMALL_CARD_LO && bank_i <= SMALL_CARD_HI) begin
                card_hit_o = 1'b1;
                card_idx_o = BW'(bank_i[1:0]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bank_mirror_mapper.sv
module bank_mirror_mapper
    import bank_mirror_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [BANK_W-1:0] rom_cnt_i,
    input  logic              wram_big_i,
    input  logic [1:0]        card_mode_i,
    output logic [1:0]        tgt_o,
    output logic [BANK_W-1:0] idx_o,
    output logic              wr_o
);
    logic              rom_ok, wram_hit, card_hit;
    logic [BANK_W-1:0] rom_idx, wram_idx, card_idx;
    map_t              map_d, map_q;

    rom_mirror #(.BW(BANK_W), .NGR(GROUPS)) rom_i (
        .bank_i   (bank_i),
        .rom_cnt_i(rom_cnt_i),
        .rom_ok_o (rom_ok),
        .rom_idx_o(rom_idx)
    );

    ram_windows #(.BW(BANK_W)) win_i (
        .bank_i     (bank_i),
        .wram_big_i (wram_big_i),
        .card_mode_i(card_mode_i),
        .wram_hit_o (wram_hit),
        .wram_idx_o (wram_idx),
        .card_hit_o (card_hit),
        .card_idx_o (card_idx)
    );

    // Card RAM beats work RAM beats ROM; anything else stays unmapped
    always_comb begin
        map_d = '{tgt: TGT_NONE, idx: '0, wr: 1'b0};
        if (card_hit) begin
            map_d = '{tgt: TGT_CARD, idx: card_idx, wr: 1'b1};
        end else if (wram_hit) begin
            map_d = '{tgt: TGT_WRAM, idx: wram_idx, wr: 1'b1};
        end else if (rom_ok) begin
            map_d = '{tgt: TGT_ROM, idx: rom_idx, wr: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '{tgt: TGT_NONE, idx: '0, wr: 1'b0};
        end else begin
            map_q <= map_d;
        end
    end

    assign tgt_o = map_q.tgt;
    assign idx_o = map_q.idx;
    assign wr_o  = map_q.wr;

    a_r11_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_ROM) |-> !wr_o);
    a_r7_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_NONE) |-> (idx_o == '0 && !wr_o));
    a_r8_wram_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_WRAM) |-> (wr_o && idx_o < BANK_W'(WRAM_BANKS)));
    a_r2_wram_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_i >= WRAM_LO && bank_i <= WRAM_LO + 8'd3) |=> (tgt_o == TGT_WRAM));
    a_r12_empty_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cnt_i == '0) |=> (tgt_o != TGT_ROM));
    a_r9_card_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_CARD) |-> wr_o);
endmodule

// File: tb/bank_mirror_mapper_tb.sv
module bank_mirror_mapper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bank = 8'h00;
    logic [7:0] rcnt = 8'd48;
    logic       big = 1'b0;
    logic [1:0] cmode = 2'd0;
    logic [1:0] tgt;
    logic [7:0] idx;
    logic       wr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bank_mirror_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .bank_i(bank), .rom_cnt_i(rcnt),
        .wram_big_i(big), .card_mode_i(cmode),
        .tgt_o(tgt), .idx_o(idx), .wr_o(wr)
    );

    task automatic check(input string req, input logic [1:0] et,
                         input logic [7:0] ei, input logic ew);
        checks++;
        if (tgt !== et || idx !== ei || wr !== ew) begin
            errors++;
            $display("FAIL %s bank=%h cnt=%0d big=%0b mode=%0d: got t=%0d i=%0d w=%0b, want t=%0d i=%0d w=%0b",
                     req, bank, rcnt, big, cmode, tgt, idx, wr, et, ei, ew);
        end
    endtask

    // Requirement arithmetic, stated region by region
    task automatic expect_of(input int b, input int n, input bit wb, input int m,
                             output logic [1:0] et, output logic [7:0] ei,
                             output logic ew, output string req);
        int g, start;
        et = 2'd0; ei = 8'd0; ew = 1'b0; req = "R7";
        g = b / 16;
        if (m == 1 && b >= 104 && b <= 127) begin
            et = 2'd3; ei = 8'(b - 104); ew = 1'b1; req = "R9";
        end else if (m == 2 && b >= 64 && b <= 95) begin
            et = 2'd3; ei = 8'(b % 4); ew = 1'b1; req = "R10";
        end else if (b >= 248 && b <= 251) begin
            et = 2'd2; ei = wb ? 8'(b - 248) : 8'd0; ew = 1'b1; req = "R8";
        end else if (b >= 128) begin
            req = "R7";
        end else if (n == 0) begin
            req = "R12";
        end else begin
            if (n == 48) begin
                start = (g >= 4) ? 32 : 16 * (g % 2); req = "R3";
            end else if (n == 64) begin
                start = (g < 2) ? 16 * g : 32 + 16 * (g % 2); req = "R4";
            end else if (n == 96) begin
                start = (g < 4) ? 16 * g : 64 + 16 * (g % 2); req = "R5";
            end else begin
                start = 16 * g; req = "R6";
            end
            et = 2'd1; ei = 8'((start + b % 16) % n); ew = 1'b0;
            req = {req, "/R11"};
        end
    endtask

    initial begin : main
        logic [1:0] et; logic [7:0] ei; logic ew; string req;
        int sizes [7] = '{48, 64, 96, 32, 128, 5, 0};
        repeat (3) @(negedge clk);
        check("R1", 2'd0, 8'd0, 1'b0);
        bank = 8'hF9; big = 1'b1;
        @(negedge clk);
        check("R1", 2'd0, 8'd0, 1'b0);
        rst_n = 1'b1;
        #1 check("R1", 2'd0, 8'd0, 1'b0);
        @(negedge clk);
        check("R2", 2'd2, 8'd1, 1'b1);
        bank = 8'h05;
        #1 check("R2", 2'd2, 8'd1, 1'b1);
        @(negedge clk);
        check("R2", 2'd1, 8'd5, 1'b0);
        foreach (sizes[s]) begin
            for (int w = 0; w < 2; w++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int b = 0; b < 256; b++) begin
                        rcnt = 8'(sizes[s]); big = w[0]; cmode = 2'(m); bank = 8'(b);
                        @(negedge clk);
                        expect_of(b, sizes[s], w[0], m, et, ei, ew, req);
                        check(req, et, ei, ew);
                    end
                end
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, got hang, want completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule